// File: doc/BRIEF.md
# Road Hit Filter with Sequential Hit Encoder

This block keeps a table of up to 46 roads. A road is a closed interval of 11-bit strip coordinates, written as one 22-bit word. Each centroid offered on the input stream is checked against every loaded road at the same moment. The result is a 46-bit comparator word with one bit per road.

A small sequencer then walks that word from the lowest road index to the highest. For every road the centroid falls in, it emits one 32-bit hit word. The index search is split into a 31-bit low section and a 15-bit high section, and their results are merged into one road index.

Roads are written through a plain load strobe. Loading a road does not disturb a centroid that is already being encoded.

Both streams use valid/ready handshakes and follow these back-pressure rules:
- The centroid stream takes one centroid per handshake. It then drops `cen_ready` until every hit for that centroid has been accepted downstream.
- On the hit stream, `hit_data` is held unchanged while `hit_valid` is high and `hit_ready` is low.

Top module: `road_hit_filter`

## Requirements
- R1: After reset, no road is loaded, `cen_ready` is high and `hit_valid` is low.
- R2: A cycle with `road_load` high and `road_sel` below 46 writes road `road_sel`, with its upper bound taken from `road_word[21:11]` and its lower bound from `road_word[10:0]`. Any `road_sel` from 46 to 63 changes no road.
- R3: A centroid matches a loaded road when lower <= centroid <= upper. Both bounds are inclusive, and this includes coordinates 0 and 2047.
- R4: A road whose lower bound is greater than its upper bound never matches. A road that has not been loaded since reset never matches.
- R5: An accepted centroid produces exactly one hit per matching road. Hits come out in strictly ascending road index, and the order runs across the boundary between index 30 and index 31.
- R6: Each hit word is {10'b0, road index[5:0], 5'b0, centroid[10:0]}, where the centroid is the one accepted.
- R7: While `hit_valid` is high and `hit_ready` is low, `hit_valid` stays high and `hit_data` stays unchanged on the next cycle.
- R8: `cen_ready` goes low in the cycle after a centroid with at least one match is accepted. It returns high in the cycle after the last hit handshake. `cen_ready` and `hit_valid` are never high together.
- R9: A centroid that matches no road produces no hit, and `cen_ready` is high again in the cycle after it is accepted.
- R10: The set of matching roads is fixed when a centroid is accepted. A road load during hit emission affects only centroids accepted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| road_load | input | 1 | Write strobe for the road table |
| road_sel | input | 6 | Index of the road to write |
| road_word | input | 22 | Road bounds: upper in [21:11], lower in [10:0] |
| cen_valid | input | 1 | A centroid is offered |
| cen_ready | output | 1 | The block accepts a centroid this cycle |
| cen_data | input | 11 | Centroid coordinate |
| hit_valid | output | 1 | A hit word is offered |
| hit_ready | input | 1 | Downstream accepts the hit word |
| hit_data | output | 32 | Hit word |

## Verification
The bench offers centroids that sit exactly on a lower or upper bound, or one step outside it. These patterns distinguish inclusive from exclusive comparisons. Centroids are also aimed at inverted, unloaded and out-of-range-selected roads, which shows whether those roads can leak a hit.

A table in which all 46 roads overlap, drained under random `hit_ready`, shows whether the ordering is correct across the 31/15 section split and whether data is held under stall. A road rewrite issued while such a burst is draining shows whether the match set was captured at acceptance or re-evaluated afterwards.

// File: rtl/rhf_pkg.sv
package rhf_pkg;
  localparam int unsigned RHF_ROADS   = 46;
  localparam int unsigned RHF_CEN_W   = 11;
  localparam int unsigned RHF_SEL_W   = 6;
  localparam int unsigned RHF_HIT_W   = 32;
  localparam int unsigned RHF_LO_SEC  = 31;
  localparam int unsigned RHF_IDX_LSB = 16;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_EMIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rhf_road_bank.sv
module rhf_road_bank #(
  parameter int unsigned N_ROADS = 46,
  parameter int unsigned CEN_W   = 11,
  parameter int unsigned SEL_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_en,
  input  logic [SEL_W-1:0]     ld_sel,
  input  logic [2*CEN_W-1:0]   ld_word,
  input  logic [CEN_W-1:0]     probe,
  output logic [N_ROADS-1:0]   match
);
  for (genvar g = 0; g < N_ROADS; g++) begin : g_road
    logic [CEN_W-1:0] lo_q;
    logic [CEN_W-1:0] hi_q;
    logic             live_q;
    logic             wr;

    assign wr = ld_en && (ld_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q   <= '0;
        hi_q   <= '0;
        live_q <= 1'b0;
      end else if (wr) begin
        hi_q   <= ld_word[2*CEN_W-1:CEN_W];
        lo_q   <= ld_word[CEN_W-1:0];
        live_q <= 1'b1;
      end
    end

    assign match[g] = live_q && (probe >= lo_q) && (probe <= hi_q);
  end
endmodule

// File: rtl/rhf_first_one.sv
module rhf_first_one #(
  parameter int unsigned W  = 31,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec[k]) begin
        found = 1'b1;
        idx   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/rhf_hit_seq.sv
module rhf_hit_seq
  import rhf_pkg::*;
#(
  parameter int unsigned N_ROADS = 46,
  parameter int unsigned CEN_W   = 11,
  parameter int unsigned SEL_W   = 6,
  parameter int unsigned HIT_W   = 32,
  parameter int unsigned LO_SEC  = 31,
  parameter int unsigned IDX_LSB = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cen_valid,
  output logic               cen_ready,
  input  logic [CEN_W-1:0]   cen_data,
  input  logic [N_ROADS-1:0] match,
  output logic               hit_valid,
  input  logic               hit_ready,
  output logic [HIT_W-1:0]   hit_data
);
  localparam int unsigned LO_W  = (N_ROADS < LO_SEC) ? N_ROADS : LO_SEC;
  localparam int unsigned HI_W  = N_ROADS - LO_W;
  localparam int unsigned LO_IW = (LO_W > 1) ? $clog2(LO_W) : 1;

  seq_state_e         state_q;
  logic [N_ROADS-1:0] pend_q;
  logic [N_ROADS-1:0] pend_rest;
  logic [CEN_W-1:0]   cen_q;
  logic [SEL_W-1:0]   cur_idx;
  logic               lo_found;
  logic [LO_IW-1:0]   lo_idx;

  rhf_first_one #(.W(LO_W), .IW(LO_IW)) u_lo_enc (
    .vec   (pend_q[LO_W-1:0]),
    .found (lo_found),
    .idx   (lo_idx)
  );

  if (HI_W > 0) begin : g_split
    localparam int unsigned HI_IW = (HI_W > 1) ? $clog2(HI_W) : 1;
    logic             hi_found;
    logic [HI_IW-1:0] hi_idx;

    rhf_first_one #(.W(HI_W), .IW(HI_IW)) u_hi_enc (
      .vec   (pend_q[N_ROADS-1:LO_W]),
      .found (hi_found),
      .idx   (hi_idx)
    );

    always_comb begin
      if (lo_found)      cur_idx = SEL_W'(lo_idx);
      else if (hi_found) cur_idx = SEL_W'(LO_W) + SEL_W'(hi_idx);
      else               cur_idx = '0;
    end
  end else begin : g_single
    assign cur_idx = SEL_W'(lo_idx);
  end

  assign pend_rest = pend_q & (pend_q - N_ROADS'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
      cen_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (cen_valid) begin
            cen_q   <= cen_data;
            pend_q  <= match;
            state_q <= (|match) ? SEQ_EMIT : SEQ_IDLE;
          end
        end
        SEQ_EMIT: begin
          if (hit_ready) begin
            pend_q <= pend_rest;
            if (pend_rest == '0) state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign cen_ready = (state_q == SEQ_IDLE);
  assign hit_valid = (state_q == SEQ_EMIT);
  assign hit_data  = (HIT_W'(cur_idx) << IDX_LSB) | HIT_W'(cen_q);
endmodule

// File: rtl/road_hit_filter.sv
module road_hit_filter
  import rhf_pkg::*;
#(
  parameter int unsigned N_ROADS = RHF_ROADS,
  parameter int unsigned CEN_W   = RHF_CEN_W,
  parameter int unsigned SEL_W   = RHF_SEL_W,
  parameter int unsigned HIT_W   = RHF_HIT_W,
  parameter int unsigned LO_SEC  = RHF_LO_SEC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               road_load,
  input  logic [SEL_W-1:0]   road_sel,
  input  logic [2*CEN_W-1:0] road_word,
  input  logic               cen_valid,
  output logic               cen_ready,
  input  logic [CEN_W-1:0]   cen_data,
  output logic               hit_valid,
  input  logic               hit_ready,
  output logic [HIT_W-1:0]   hit_data
);
  logic [N_ROADS-1:0] cmp_word;

  rhf_road_bank #(.N_ROADS(N_ROADS), .CEN_W(CEN_W), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (road_load),
    .ld_sel  (road_sel),
    .ld_word (road_word),
    .probe   (cen_data),
    .match   (cmp_word)
  );

  rhf_hit_seq #(
    .N_ROADS (N_ROADS),
    .CEN_W   (CEN_W),
    .SEL_W   (SEL_W),
    .HIT_W   (HIT_W),
    .LO_SEC  (LO_SEC),
    .IDX_LSB (RHF_IDX_LSB)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cen_valid (cen_valid),
    .cen_ready (cen_ready),
    .cen_data  (cen_data),
    .match     (cmp_word),
    .hit_valid (hit_valid),
    .hit_ready (hit_ready),
    .hit_data  (hit_data)
  );
endmodule

// File: rtl/rhf_checker.sv
module rhf_checker #(
  parameter int unsigned N_ROADS = 46
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cen_ready,
  input logic        hit_valid,
  input logic        hit_ready,
  input logic [31:0] hit_data
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (cen_ready && !hit_valid));

  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_data)));

  // R8
  mutual_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_valid && cen_ready));

  // R6
  hit_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (hit_data[31:22] == 10'd0 && hit_data[15:11] == 5'd0));

  // R5
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (32'(hit_data[21:16]) < N_ROADS));

  // R5
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_ready) |=> (!hit_valid || (hit_data[21:16] > $past(hit_data[21:16]))));

  // R6
  same_centroid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_ready) |=> (!hit_valid || (hit_data[10:0] == $past(hit_data[10:0]))));
endmodule

bind road_hit_filter rhf_checker #(.N_ROADS(N_ROADS)) u_rhf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cen_ready (cen_ready),
  .hit_valid (hit_valid),
  .hit_ready (hit_ready),
  .hit_data  (hit_data)
);

// File: tb/test_road_hit_filter.sv
`timescale 1ns/1ps
module test_road_hit_filter;
  localparam int NR = 46;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        road_load = 1'b0;
  logic [5:0]  road_sel = '0;
  logic [21:0] road_word = '0;
  logic        cen_valid = 1'b0;
  logic        cen_ready;
  logic [10:0] cen_data = '0;
  logic        hit_valid;
  logic        hit_ready;
  logic [31:0] hit_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit bp_mode = 1'b0;
  bit model_on = 1'b0;

  int m_lo [NR];
  int m_hi [NR];
  bit m_ld [NR];
  logic [31:0] m_q[$];
  logic [31:0] got_q[$];

  always #4 clk = ~clk;

  road_hit_filter i_road_hit_filter (
    .clk (clk), .rst_n (rst_n), .road_load (road_load), .road_sel (road_sel),
    .road_word (road_word), .cen_valid (cen_valid), .cen_ready (cen_ready),
    .cen_data (cen_data), .hit_valid (hit_valid), .hit_ready (hit_ready),
    .hit_data (hit_data)
  );

  function automatic logic [31:0] mk_hit(int idx, int c);
    return {10'd0, 6'(idx), 5'd0, 11'(c)};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) hit_ready <= bp_mode ? 1'($urandom % 2) : 1'b1;

  // reference model and monitor, then per-cycle comparison
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_q.delete();
      for (int i = 0; i < NR; i++) m_ld[i] = 1'b0;
    end else begin
      if (hit_valid && hit_ready) got_q.push_back(hit_data);
      if (cen_valid && m_q.size() == 0) begin
        for (int i = 0; i < NR; i++)
          if (m_ld[i] && int'(cen_data) >= m_lo[i] && int'(cen_data) <= m_hi[i])
            m_q.push_back(mk_hit(i, int'(cen_data)));
      end else if (m_q.size() > 0 && hit_ready) begin
        void'(m_q.pop_front());
      end
      if (road_load && int'(road_sel) < NR) begin
        m_hi[road_sel] = int'(road_word[21:11]);
        m_lo[road_sel] = int'(road_word[10:0]);
        m_ld[road_sel] = 1'b1;
      end
    end
    #2;
    if (model_on) begin
      // R8: readiness follows the pending-hit count
      check(cen_ready == (m_q.size() == 0), "R8 cen_ready", 32'(cen_ready), 32'(m_q.size() == 0));
      // R5: a hit is offered exactly while hits remain
      check(hit_valid == (m_q.size() != 0), "R5 hit_valid", 32'(hit_valid), 32'(m_q.size() != 0));
      // R6: hit word content
      if (m_q.size() != 0) check(hit_data == m_q[0], "R6 hit_data", hit_data, m_q[0]);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic load_road(int sel, int lo, int hi);
    @(negedge clk);
    road_load = 1'b1;
    road_sel  = 6'(sel);
    road_word = {11'(hi), 11'(lo)};
    @(negedge clk);
    road_load = 1'b0;
  endtask

  task automatic send_cen(int c, string req, int exp_n);
    logic [31:0] exp_l[$];
    @(negedge clk);
    while (!cen_ready) @(negedge clk);
    for (int i = 0; i < NR; i++)
      if (m_ld[i] && c >= m_lo[i] && c <= m_hi[i]) exp_l.push_back(mk_hit(i, c));
    got_q.delete();
    cen_valid = 1'b1;
    cen_data  = 11'(c);
    @(negedge clk);
    cen_valid = 1'b0;
    if (exp_l.size() == 0) begin
      // R9: released one cycle after acceptance, nothing offered
      check(cen_ready && !hit_valid, "R9 release", {hit_valid, cen_ready}, 32'b01);
    end
    while (!cen_ready) @(negedge clk);
    check(exp_l.size() == exp_n, {req, " expected count"}, exp_l.size(), exp_n);
    check(got_q.size() == exp_l.size(), {req, " hit count"}, got_q.size(), exp_l.size());
    for (int i = 0; i < exp_l.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_l[i], {req, " hit order"}, got_q[i], exp_l[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(cen_ready === 1'b1, "R1 ready", 32'(cen_ready), 32'd1);
    check(hit_valid === 1'b0, "R1 no hit", 32'(hit_valid), 32'd0);
    model_on = 1'b1;
    send_cen(100, "R1 R4 unloaded", 0);

    load_road(0, 100, 200);
    load_road(1, 150, 150);
    load_road(2, 300, 50);      // inverted
    load_road(30, 199, 199);
    load_road(31, 200, 210);
    load_road(45, 0, 2047);
    send_cen(99, "R3 below lower", 1);
    send_cen(100, "R3 on lower", 2);
    send_cen(150, "R3 point road", 3);
    send_cen(199, "R5 index 30", 3);
    send_cen(200, "R3 on upper R5 index 31", 3);
    send_cen(201, "R3 above upper", 2);
    send_cen(300, "R4 inverted", 1);
    send_cen(0, "R3 zero", 1);
    send_cen(2047, "R3 max", 1);

    load_road(45, 2047, 2047);
    send_cen(1000, "R9 no match", 0);
    load_road(46, 1000, 1000);
    load_road(63, 1000, 1000);
    send_cen(1000, "R2 high select ignored", 0);
    send_cen(2047, "R2 reload upper field", 1);

    for (int i = 0; i < NR; i++) load_road(i, 500, 600);
    bp_mode = 1'b1;
    send_cen(550, "R5 R7 all roads", 46);
    send_cen(600, "R5 R7 all roads upper", 46);
    fork
      send_cen(550, "R10 capture", 46);
      begin
        repeat (5) @(negedge clk);
        load_road(0, 0, 0);
      end
    join
    send_cen(550, "R10 later centroid", 45);
    bp_mode = 1'b0;
    send_cen(0, "R2 road written", 1);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule